// File: doc/BRIEF.md
# Block-Transfer DMA Channel

This block is a single-channel engine that copies a block of words between main memory and one peripheral without the processor touching each word. Software loads a start address and a word count, then writes the status/control word to choose the direction and interrupt enable. That write launches the block. The engine then competes for memory one word at a time. Every granted memory cycle moves one word, the address steps forward, and the remaining count steps down.

When the last word has moved, the engine flags completion and, if enabled, raises an interrupt. Software clears the interrupt either by reading the status word or by writing a 1 to its interrupt bit. Data passes through a single internal holding register. In the memory-to-device direction a word is fetched from memory and then offered to the device. In the other direction a word is taken from the device and then written to memory.

Top module: `dma_top`

## Requirements
- R1: After reset the status word reads 0x00000002 (done set, everything else clear), the address and count registers read 0, the interrupt line is low, and no memory request, device offer or device acceptance is active.
- R2: `reg_sel` encodes address = 0, count = 1, status/control = 2. In the status/control word, bit 0 is the direction, bit 1 is done, bit 30 is interrupt enable and bit 31 is the interrupt request. Reading a register with `reg_rd` low has no side effect.
- R3: Writing status/control while idle latches the direction and enable bits. With a nonzero count this clears done and starts the block. With a zero count, done stays set, no memory or device activity follows, and the interrupt is raised if enable was written as 1.
- R4: With direction 1, each granted request is a memory read (`mem_we` low). The word returned in that cycle is then offered on `dev_out_data`, held stable until `dev_out_ready`, and words reach the device in address order.
- R5: With direction 0, a word accepted from the device (`dev_in_valid` and `dev_in_ready`) is written to memory at the current address with `mem_we` high, in the order received.
- R6: The memory address advances by one on every granted request. After a block of N words the address register reads start + N and the count register reads 0.
- R7: At most one word is held at a time. A memory request stays asserted with a stable address until it is granted, and each grant moves exactly one word.
- R8: When the last word completes, done reads 1 and the engine goes quiet. If interrupt enable is 1, bit 31 sets and the `irq` output goes high.
- R9: A status read pulse or a status write with bit 31 = 1 clears the interrupt request and drops `irq` on the next cycle. If such a clear falls in the same cycle as completion, the completion wins and `irq` stays high.
- R10: While a block is active, writes to the address, count or status/control registers leave them unchanged, except that a status write with bit 31 = 1 still clears the interrupt request.
- R11: With interrupt enable 0, completion sets done but never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 status/control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt when selecting status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_req | output | 1 | Memory cycle request |
| mem_gnt | input | 1 | Memory cycle granted this clock |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Data read from memory, valid in the grant cycle |
| dev_out_valid | output | 1 | Word offered to the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_out_data | output | DW | Word sent to the device |
| dev_in_valid | input | 1 | Device presents a word |
| dev_in_ready | output | 1 | Engine can accept a device word |
| dev_in_data | input | DW | Word from the device |
| irq | output | 1 | Interrupt request, active high |

## Verification
The two functions that can land on the same edge are completion of the final word, which sets the interrupt request, and the software clear, done by a status read or a bit-31 write. The bench loads a device word into a one-word block and holds the memory grant off. It then raises the grant in the same cycle as a status read pulse. The read data must still show done = 0, and one cycle later `irq` must be high with done = 1, because the set takes precedence. A separate case leaves an interrupt pending from an earlier block while a new block runs. In that case, ignored writes must not disturb the active block, while a bit-31 write still clears the pending request.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int REG_W    = 32;
    localparam int BIT_DIR  = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_IE   = 30;
    localparam int BIT_IRQ  = 31;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic irq;
        logic ie;
        logic done;
        logic dir;
    } stat_t;

    typedef struct packed {
        logic step_addr;
        logic step_cnt;
    } step_t;

    function automatic logic [REG_W-1:0] status_word(stat_t s);
        logic [REG_W-1:0] w;
        w           = '0;
        w[BIT_DIR]  = s.dir;
        w[BIT_DONE] = s.done;
        w[BIT_IE]   = s.ie;
        w[BIT_IRQ]  = s.irq;
        return w;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_sel_e         sel,
    input  logic             wr,
    input  logic             rd,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  step_t            step,
    output logic [AW-1:0]    addr,
    output logic             busy,
    output logic             dir,
    output logic             done,
    output logic             irq,
    output logic             fin
);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          dir_q, ie_q, done_q, irq_q, busy_q;
    logic          wr_idle, wr_stat, irq_set, irq_clr;
    stat_t         st;

    always_comb begin
        fin     = step.step_cnt && (cnt_q == CW'(1));
        wr_idle = wr && !busy_q;
        wr_stat = wr && (sel == SEL_STAT);
        irq_set = (fin && ie_q) ||
                  (wr_idle && wr_stat && (cnt_q == '0) && wdata[BIT_IE]);
        irq_clr = (rd && (sel == SEL_STAT)) || (wr_stat && wdata[BIT_IRQ]);
        st      = '{irq: irq_q, ie: ie_q, done: done_q, dir: dir_q};
        unique case (sel)
            SEL_ADDR: rdata = REG_W'(addr_q);
            SEL_CNT:  rdata = REG_W'(cnt_q);
            SEL_STAT: rdata = status_word(st);
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            ie_q   <= 1'b0;
            done_q <= 1'b1;
            irq_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (step.step_addr) addr_q <= addr_q + AW'(1);
            if (step.step_cnt)  cnt_q  <= cnt_q - CW'(1);
            if (fin) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
            if (wr_idle) begin
                unique case (sel)
                    SEL_ADDR: addr_q <= wdata[AW-1:0];
                    SEL_CNT:  cnt_q  <= wdata[CW-1:0];
                    SEL_STAT: begin
                        dir_q <= wdata[BIT_DIR];
                        ie_q  <= wdata[BIT_IE];
                        if (cnt_q != '0) begin
                            busy_q <= 1'b1;
                            done_q <= 1'b0;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            irq_q <= irq_set | (irq_q & ~irq_clr);
        end
    end

    assign addr = addr_q;
    assign busy = busy_q;
    assign dir  = dir_q;
    assign done = done_q;
    assign irq  = irq_q;

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic          dir,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output step_t         step
);

    logic [DW-1:0] hold_q;
    logic          full_q;
    logic          fetch, store;

    always_comb begin
        fetch         = busy && dir && !full_q;
        store         = busy && !dir && full_q;
        mem_req       = fetch || store;
        mem_we        = store;
        dev_out_valid = busy && dir && full_q;
        dev_in_ready  = busy && !dir && !full_q;
        step.step_addr = mem_req && mem_gnt;
        step.step_cnt  = (dev_out_valid && dev_out_ready) || (store && mem_gnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (fetch && mem_gnt) begin
            hold_q <= mem_rdata;
            full_q <= 1'b1;
        end else if (dev_in_ready && dev_in_valid) begin
            hold_q <= dev_in_data;
            full_q <= 1'b1;
        end else if (step.step_cnt) begin
            full_q <= 1'b0;
        end
    end

    assign mem_wdata    = hold_q;
    assign dev_out_data = hold_q;

endmodule

// File: rtl/dma_top.sv
module dma_top
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          irq
);

    step_t    step_w;
    logic     busy_w, dir_w, done_w, fin_w;
    reg_sel_e sel_w;

    assign sel_w = reg_sel_e'(reg_sel);

    dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel_w),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .step  (step_w),
        .addr  (mem_addr),
        .busy  (busy_w),
        .dir   (dir_w),
        .done  (done_w),
        .irq   (irq),
        .fin   (fin_w)
    );

    dma_xfer #(.DW(DW)) u_xfer (
        .clk           (clk),
        .rst           (rst),
        .busy          (busy_w),
        .dir           (dir_w),
        .mem_req       (mem_req),
        .mem_gnt       (mem_gnt),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data),
        .step          (step_w)
    );

endmodule

// File: rtl/dma_top_chk.sv
module dma_top_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          dev_out_valid,
    input logic          dev_out_ready,
    input logic [DW-1:0] dev_out_data,
    input logic          dev_in_ready,
    input logic [1:0]    reg_sel,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          irq,
    input logic          busy,
    input logic          dir,
    input logic          done,
    input logic          fin
);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_gnt |=> mem_addr == AW'($past(mem_addr) + AW'(1)));

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
        dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !dev_out_valid && !dev_in_ready);

    assert_irq_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> done);

    assert_busy_write_R10: assert property (@(posedge clk) disable iff (rst)
        busy && reg_wr |=> $stable(dir));

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_sel == 2'd2 && !fin |=> !irq);

endmodule

bind dma_top dma_top_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req       (mem_req),
    .mem_gnt       (mem_gnt),
    .mem_addr      (mem_addr),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .dev_in_ready  (dev_in_ready),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .irq           (irq),
    .busy          (busy_w),
    .dir           (dir_w),
    .done          (done_w),
    .fin           (fin_w)
);

// File: tb/tb_dma_top.sv
module tb_dma_top;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    reg_sel = 2'd2;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we;
    logic          mem_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          dev_out_valid, dev_in_ready;
    logic          dev_out_ready = 1'b0;
    logic          dev_in_valid = 1'b0;
    logic [DW-1:0] dev_out_data;
    logic [DW-1:0] dev_in_data = '0;
    logic          irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
        return (DW'(a) * 32'h0001_0003) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [DW-1:0] dev_word(int s, int k);
        return 32'h1000_0000 + DW'(s * 256 + k);
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    dma_top dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid),
        .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
        .dev_in_data(dev_in_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog expired act=%h exp=%h", 0, 1);
        summary();
        $finish;
    end

    task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 2'd2;
    endtask

    task automatic reg_read_pulse();
        @(negedge clk);
        reg_sel = 2'd2; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
        reg_sel = 2'd2;
    endtask

    task automatic xfer_run(input bit dir, input int n, input logic [AW-1:0] base,
                            input int s);
        int widx = 0;
        int didx = 0;
        logic [31:0] st;
        for (int cyc = 0; cyc < 400; cyc++) begin
            mem_gnt       = ((cyc + s) % 3) != 0;
            dev_out_ready = ((cyc + 2 * s) % 4) != 3;
            dev_in_valid  = !dir && (((cyc + s) % 5) != 4);
            dev_in_data   = dev_word(s, didx);
            #1;
            peek(2'd2, st);
            if (st[1]) break;
            if (mem_req && mem_gnt) begin
                chk(mem_addr == AW'(base + AW'(widx)), "R6 address per grant",
                    32'(mem_addr), 32'(base + AW'(widx)));
                chk(mem_we == !dir, dir ? "R4 read strobe" : "R5 write strobe",
                    32'(mem_we), 32'(!dir));
                if (!dir)
                    chk(mem_wdata == dev_word(s, widx), "R5 memory write data",
                        mem_wdata, dev_word(s, widx));
                widx++;
            end
            if (dir && dev_out_valid && dev_out_ready) begin
                chk(dev_out_data == mem_word(AW'(base + AW'(didx))), "R4 device word",
                    dev_out_data, mem_word(AW'(base + AW'(didx))));
                didx++;
            end
            if (!dir && dev_in_valid && dev_in_ready) didx++;
            @(negedge clk);
        end
        mem_gnt = 1'b0; dev_out_ready = 1'b0; dev_in_valid = 1'b0;
        chk(widx == n, "R7 one grant per word", 32'(widx), 32'(n));
        chk(didx == n, "R4 R5 device word count", 32'(didx), 32'(n));
    endtask

    task automatic xfer_start(input bit dir, input bit ie, input int n,
                              input logic [AW-1:0] base);
        reg_write(2'd0, 32'(base));
        reg_write(2'd1, 32'(n));
        reg_write(2'd2, (32'(ie) << 30) | 32'(dir));
    endtask

    task automatic xfer_check_end(input bit ie, input int n, input logic [AW-1:0] base);
        logic [31:0] v;
        peek(2'd2, v);
        chk(v[1] == 1'b1, "R8 done after block", v, 32'h2);
        chk(irq == ie, ie ? "R8 irq raised" : "R11 no irq", 32'(irq), 32'(ie));
        chk(v[31] == ie, "R2 irq bit 31", v, 32'(ie) << 31);
        peek(2'd0, v);
        chk(v == 32'(AW'(base + AW'(n))), "R6 final address", v, 32'(AW'(base + AW'(n))));
        peek(2'd1, v);
        chk(v == 32'd0, "R6 final count", v, 0);
    endtask

    initial begin
        logic [31:0] v;
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        peek(2'd2, v);
        chk(v == 32'h0000_0002, "R1 reset status", v, 32'h2);
        peek(2'd0, v);
        chk(v == 0, "R1 reset address", v, 0);
        peek(2'd1, v);
        chk(v == 0, "R1 reset count", v, 0);
        chk({irq, mem_req, dev_out_valid, dev_in_ready} == 4'b0, "R1 quiet outputs",
            32'({irq, mem_req, dev_out_valid, dev_in_ready}), 0);

        s = 0;
        for (int d = 0; d < 2; d++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int n = 0; n < 6; n++) begin
                    logic [AW-1:0] base;
                    base = AW'(100 * s + 7);
                    xfer_start(d[0], ie[0], n, base);
                    peek(2'd2, v);
                    chk(v[0] == d[0] && v[30] == ie[0], "R2 control bits latched",
                        v, (32'(ie) << 30) | 32'(d));
                    chk(v[1] == (n == 0), "R3 done after start", v, 32'(n == 0) << 1);
                    if (n == 0) begin
                        for (int k = 0; k < 4; k++) begin
                            @(negedge clk);
                            #1;
                            chk(!mem_req && !dev_out_valid && !dev_in_ready,
                                "R3 zero count idle", 32'(mem_req), 0);
                        end
                        chk(irq == ie[0], "R3 zero count irq", 32'(irq), 32'(ie));
                    end else begin
                        xfer_run(d[0], n, base, s);
                    end
                    xfer_check_end(ie[0], n, base);
                    if (n % 2 == 1) reg_read_pulse();
                    else reg_write(2'd2, 32'h8000_0000);
                    #1;
                    chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 0);
                    s++;
                end
            end
        end

        // R10: leave irq pending, then start a new block and try to disturb it
        xfer_start(1'b0, 1'b1, 1, 16'd500);
        xfer_run(1'b0, 1, 16'd500, 40);
        chk(irq == 1'b1, "R8 pending irq", 32'(irq), 1);
        xfer_start(1'b1, 1'b1, 3, 16'd8);
        reg_write(2'd0, 32'd40);
        reg_write(2'd1, 32'd9);
        reg_write(2'd2, 32'h0000_0000);
        peek(2'd0, v);
        chk(v == 32'd8, "R10 address write ignored", v, 8);
        peek(2'd1, v);
        chk(v == 32'd3, "R10 count write ignored", v, 3);
        peek(2'd2, v);
        chk(v == 32'hC000_0001, "R10 control write ignored", v, 32'hC000_0001);
        reg_write(2'd2, 32'h8000_0000);
        peek(2'd2, v);
        chk(v == 32'h4000_0001, "R10 irq clear while busy", v, 32'h4000_0001);
        chk(irq == 1'b0, "R10 irq line low", 32'(irq), 0);
        xfer_run(1'b1, 3, 16'd8, 41);
        xfer_check_end(1'b1, 3, 16'd8);
        reg_read_pulse();

        // R9: completion and status read in the same cycle
        xfer_start(1'b0, 1'b1, 1, 16'd20);
        @(negedge clk);
        dev_in_valid = 1'b1; dev_in_data = dev_word(99, 0);
        @(negedge clk);
        dev_in_valid = 1'b0;
        #1;
        chk(mem_req && mem_we, "R5 store requested", 32'({mem_req, mem_we}), 3);
        @(negedge clk);
        mem_gnt = 1'b1; reg_sel = 2'd2; reg_rd = 1'b1;
        #1;
        chk(mem_addr == 16'd20 && mem_wdata == dev_word(99, 0), "R5 store word",
            mem_wdata, dev_word(99, 0));
        chk(reg_rdata == 32'h4000_0000, "R9 read before completion", reg_rdata,
            32'h4000_0000);
        @(negedge clk);
        mem_gnt = 1'b0; reg_rd = 1'b0;
        #1;
        chk(irq == 1'b1, "R9 set wins over clear", 32'(irq), 1);
        chk(reg_rdata == 32'hC000_0002, "R9 status after collision", reg_rdata,
            32'hC000_0002);
        reg_read_pulse();
        #1;
        chk(irq == 1'b0, "R9 later read clears", 32'(irq), 0);

        summary();
        $finish;
    end

endmodule